// File: doc/BRIEF.md
# Virtual Interrupt List-Register CPU Interface

This block is the guest-facing interrupt interface of one virtual CPU. It keeps a small table of list entries. Each entry holds a 10-bit virtual interrupt number, a 3-bit originating CPU number, a two-bit life-cycle state, a priority, an end-of-interrupt notify flag and a hardware-linked flag. Entry contents are written by the supervising logic through a one-cycle load port that names the entry to overwrite.

The guest reaches the block through a small register bus. It can read and write an enable control and a priority mask. It reads an acknowledge register to claim the most urgent pending interrupt. It writes an end-of-interrupt register to retire an interrupt it has finished. A level virtual-IRQ output tells the guest CPU that work is waiting. Two status vectors go back to the supervisor. One flags entries that are empty. The other flags retired entries that asked to be notified.

Top module: `lr_cpu_if`

## Requirements
- R1: After reset every entry is invalid, the control and priority mask registers read 0, `virqOut` is low, `emptyStatus` is all ones and `eoiStatus` is all zeros; a load writes all fields of entry `ldIndex` at the clock edge.
- R2: State encoding is 00 invalid, 01 pending, 10 active, 11 pending-and-active; `emptyStatus[i]` is 1 exactly when entry i is in state 00.
- R3: A read of bus address 2 returns the originating CPU number in bits [12:10] and the interrupt number in bits [9:0], with zeros above. The entry returned is the one in state 01 or 11 with the numerically lowest priority value; ties go to the lowest entry index. That entry becomes state 10 after the read cycle.
- R4: If no entry is in state 01 or 11, or control bit 0 is clear, an address-2 read returns 1023 and changes no entry.
- R5: If the selected entry has its hardware-linked flag set, an address-2 read returns 1023 and changes no entry.
- R6: A write to bus address 3 takes the interrupt number from bits [9:0] and the CPU number from bits [12:10]. The lowest-index entry that is not invalid and matches both fields goes to state 00.
- R7: An address-3 write that matches no entry changes nothing.
- R8: `eoiStatus[i]` is 1 exactly when entry i is in state 00 and its notify flag is set; it follows every load and bus access.
- R9: `virqOut` is high exactly when control bit 0 is set and at least one entry is in state 01 or 11.
- R10: Address 0 holds the enable in bit 0, and address 1 holds a 5-bit priority mask in bits [4:0]. Both read back with zero upper bits. A read of address 3 returns 0, and a write to address 2 has no effect.
- R11: When a load and an acknowledge or end-of-interrupt update hit the same entry in one cycle, the entry holds the loaded contents afterwards; the bus read still returns the pre-edge entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | Load strobe for one entry |
| ldIndex | input | 2 | Entry to load |
| ldVirtId | input | 10 | Loaded interrupt number |
| ldCpuId | input | 3 | Loaded originating CPU number |
| ldState | input | 2 | Loaded state |
| ldPrio | input | 5 | Loaded priority (lower is more urgent) |
| ldEoiNotify | input | 1 | Loaded notify-on-retire flag |
| ldHwLink | input | 1 | Loaded hardware-linked flag |
| busValid | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 write, 0 read |
| busAddr | input | 2 | Register select: 0 control, 1 mask, 2 acknowledge, 3 end-of-interrupt |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| virqOut | output | 1 | Level virtual interrupt request |
| eoiStatus | output | 4 | Retired-and-notify flags per entry |
| emptyStatus | output | 4 | Invalid-state flags per entry |

## Verification
A guest acknowledge or retire can land on the same entry, in the same cycle, as a load from the supervisor. The bench provokes both cases. It drives an acknowledge read together with a load into the entry the read is claiming. It also drives a retire write together with a load into the entry the write matches. It then judges the outcome at the ports: the read data must show the old entry, and a later acknowledge or the empty flag must show that the loaded contents survived.

// File: rtl/lr_cpu_if_pkg.sv
package lr_cpu_if_pkg;
  parameter int ID_W   = 10;
  parameter int CPU_W  = 3;
  parameter int PRIO_W = 5;
  parameter int DATA_W = 32;

  localparam logic [ID_W-1:0] NO_IRQ_ID = '1; // 1023 for a 10-bit field

  typedef enum logic [1:0] {
    ST_INVALID = 2'b00,
    ST_PEND    = 2'b01,
    ST_ACTIVE  = 2'b10,
    ST_PENDACT = 2'b11
  } lr_state_e;

  typedef struct packed {
    logic [ID_W-1:0]   virtId;
    logic [CPU_W-1:0]  cpuId;
    lr_state_e         state;
    logic [PRIO_W-1:0] prio;
    logic              eoiNotify;
    logic              hwLink;
  } lr_entry_t;

  typedef struct packed {
    logic              ackStb;
    logic              eoiStb;
    logic [ID_W-1:0]   eoiId;
    logic [CPU_W-1:0]  eoiCpu;
  } lr_strobe_t;
endpackage

// File: rtl/lr_datapath.sv
module lr_datapath
  import lr_cpu_if_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ldValid,
  input  logic [IDX_W-1:0]       ldIndex,
  input  lr_entry_t              ldEntry,
  input  lr_strobe_t             strb,
  output logic                   selValid,
  output logic                   selHw,
  output logic [ID_W-1:0]        selVirtId,
  output logic [CPU_W-1:0]       selCpuId,
  output logic                   anyPending,
  output logic [NUM_ENTRIES-1:0] eoiStatus,
  output logic [NUM_ENTRIES-1:0] emptyStatus
);
  lr_entry_t         entries [NUM_ENTRIES];
  logic [IDX_W-1:0]  selIdx;
  logic [PRIO_W-1:0] bestPrio;
  logic [IDX_W-1:0]  matchIdx;
  logic              matchFound;

  // Most urgent pending entry: strict compare keeps the lowest index on ties.
  always_comb begin
    selValid = 1'b0;
    selIdx   = '0;
    bestPrio = '1;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (entries[i].state[0] && (!selValid || entries[i].prio < bestPrio)) begin
        selValid = 1'b1;
        selIdx   = IDX_W'(i);
        bestPrio = entries[i].prio;
      end
    end
  end

  assign selHw      = entries[selIdx].hwLink;
  assign selVirtId  = entries[selIdx].virtId;
  assign selCpuId   = entries[selIdx].cpuId;
  assign anyPending = selValid;

  // First live entry matching both retire fields.
  always_comb begin
    matchFound = 1'b0;
    matchIdx   = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!matchFound && entries[i].state != ST_INVALID &&
          entries[i].virtId == strb.eoiId && entries[i].cpuId == strb.eoiCpu) begin
        matchFound = 1'b1;
        matchIdx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!rstN) begin
        entries[i] <= '0;
      end else if (ldValid && ldIndex == IDX_W'(i)) begin
        entries[i] <= ldEntry;
      end else if (strb.ackStb && selIdx == IDX_W'(i)) begin
        entries[i].state <= ST_ACTIVE;
      end else if (strb.eoiStb && matchFound && matchIdx == IDX_W'(i)) begin
        entries[i].state <= ST_INVALID;
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_status
      assign emptyStatus[g] = (entries[g].state == ST_INVALID);
      assign eoiStatus[g]   = (entries[g].state == ST_INVALID) && entries[g].eoiNotify;
    end
  endgenerate
endmodule

// File: rtl/lr_control.sv
module lr_control
  import lr_cpu_if_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              selValid,
  input  logic              selHw,
  input  logic [ID_W-1:0]   selVirtId,
  input  logic [CPU_W-1:0]  selCpuId,
  input  logic              anyPending,
  output lr_strobe_t        strb,
  output logic [DATA_W-1:0] busRdata,
  output logic              virqOut
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_ACK  = 2'd2;
  localparam logic [1:0] A_EOI  = 2'd3;

  logic              ctrlEn;
  logic [PRIO_W-1:0] prioMask;
  logic              rdAck;
  logic              ackHit;
  logic              unusedWdata;

  assign unusedWdata = ^busWdata[DATA_W-1:ID_W+CPU_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn   <= 1'b0;
      prioMask <= '0;
    end else if (busValid && busWrite) begin
      if (busAddr == A_CTRL) ctrlEn   <= busWdata[0];
      if (busAddr == A_MASK) prioMask <= busWdata[PRIO_W-1:0];
    end
  end

  assign rdAck  = busValid && !busWrite && busAddr == A_ACK;
  assign ackHit = ctrlEn && selValid && !selHw;

  always_comb begin
    strb        = '0;
    strb.ackStb = rdAck && ackHit;
    strb.eoiStb = busValid && busWrite && busAddr == A_EOI;
    strb.eoiId  = busWdata[ID_W-1:0];
    strb.eoiCpu = busWdata[ID_W+CPU_W-1:ID_W];
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      A_CTRL: busRdata[0] = ctrlEn;
      A_MASK: busRdata[PRIO_W-1:0] = prioMask;
      A_ACK:  busRdata[ID_W+CPU_W-1:0] = ackHit ? {selCpuId, selVirtId}
                                                : {{CPU_W{1'b0}}, NO_IRQ_ID};
      A_EOI:  busRdata = '0;
    endcase
  end

  assign virqOut = ctrlEn && anyPending;
endmodule

// File: rtl/lr_cpu_if.sv
module lr_cpu_if
  import lr_cpu_if_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ldValid,
  input  logic [IDX_W-1:0]       ldIndex,
  input  logic [ID_W-1:0]        ldVirtId,
  input  logic [CPU_W-1:0]       ldCpuId,
  input  logic [1:0]             ldState,
  input  logic [PRIO_W-1:0]      ldPrio,
  input  logic                   ldEoiNotify,
  input  logic                   ldHwLink,
  input  logic                   busValid,
  input  logic                   busWrite,
  input  logic [1:0]             busAddr,
  input  logic [DATA_W-1:0]      busWdata,
  output logic [DATA_W-1:0]      busRdata,
  output logic                   virqOut,
  output logic [NUM_ENTRIES-1:0] eoiStatus,
  output logic [NUM_ENTRIES-1:0] emptyStatus
);
  lr_entry_t        ldEntry;
  lr_strobe_t       strb;
  logic             selValid;
  logic             selHw;
  logic [ID_W-1:0]  selVirtId;
  logic [CPU_W-1:0] selCpuId;
  logic             anyPending;

  always_comb begin
    ldEntry.virtId    = ldVirtId;
    ldEntry.cpuId     = ldCpuId;
    ldEntry.state     = lr_state_e'(ldState);
    ldEntry.prio      = ldPrio;
    ldEntry.eoiNotify = ldEoiNotify;
    ldEntry.hwLink    = ldHwLink;
  end

  lr_datapath #(.NUM_ENTRIES(NUM_ENTRIES)) u_datapath (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldIndex(ldIndex), .ldEntry(ldEntry),
    .strb(strb), .selValid(selValid), .selHw(selHw), .selVirtId(selVirtId),
    .selCpuId(selCpuId), .anyPending(anyPending), .eoiStatus(eoiStatus),
    .emptyStatus(emptyStatus)
  );

  lr_control u_control (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .selValid(selValid), .selHw(selHw), .selVirtId(selVirtId),
    .selCpuId(selCpuId), .anyPending(anyPending), .strb(strb), .busRdata(busRdata),
    .virqOut(virqOut)
  );
endmodule

// File: rtl/lr_cpu_if_checker.sv
module lr_cpu_if_checker #(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   ldValid,
  input logic [IDX_W-1:0]       ldIndex,
  input logic [1:0]             ldState,
  input logic                   busValid,
  input logic                   busWrite,
  input logic [1:0]             busAddr,
  input logic [31:0]            busRdata,
  input logic                   virqOut,
  input logic [NUM_ENTRIES-1:0] eoiStatus,
  input logic [NUM_ENTRIES-1:0] emptyStatus
);
  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    ldValid |=> (emptyStatus[$past(ldIndex)] == ($past(ldState) == 2'b00))); // R2

  AST_IDLE_ACK_NONE: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busAddr == 2'd2 && !virqOut) |-> busRdata == 32'd1023); // R4

  AST_ACK_KEEPS_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busAddr == 2'd2 && !ldValid) |=> emptyStatus == $past(emptyStatus)); // R3

  AST_EOI_NO_REFILL: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == 2'd3 && !ldValid)
      |=> $countones(emptyStatus) >= $past($countones(emptyStatus))); // R6

  AST_NOTIFY_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (eoiStatus & ~emptyStatus) == '0); // R8

  AST_VIRQ_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    virqOut |-> emptyStatus != '1); // R9
endmodule

bind lr_cpu_if lr_cpu_if_checker #(.NUM_ENTRIES(NUM_ENTRIES)) u_checker (.*);

// File: tb/lr_cpu_if_bench.sv
module lr_cpu_if_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldValid = 1'b0;
  logic [1:0]  ldIndex = '0;
  logic [9:0]  ldVirtId = '0;
  logic [2:0]  ldCpuId = '0;
  logic [1:0]  ldState = '0;
  logic [4:0]  ldPrio = '0;
  logic        ldEoiNotify = 1'b0;
  logic        ldHwLink = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        virqOut;
  logic [3:0]  eoiStatus;
  logic [3:0]  emptyStatus;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lr_cpu_if u_lr_cpu_if (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setLoad(input logic [1:0] idx, input logic [9:0] id, input logic [2:0] cpu,
                         input logic [1:0] st, input logic [4:0] pr, input logic nt, input logic hw);
    ldValid = 1'b1; ldIndex = idx; ldVirtId = id; ldCpuId = cpu;
    ldState = st; ldPrio = pr; ldEoiNotify = nt; ldHwLink = hw;
  endtask

  task automatic doLoad(input logic [1:0] idx, input logic [9:0] id, input logic [2:0] cpu,
                        input logic [1:0] st, input logic [4:0] pr, input logic nt, input logic hw);
    @(negedge clk);
    setLoad(idx, id, cpu, st, pr, nt, hw);
    @(posedge clk); #1 ldValid = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1 busValid = 1'b0;
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1 busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    @(negedge clk);
    check("R1 empty after reset", emptyStatus, 4'hF);
    check("R1 notify after reset", eoiStatus, 4'h0);
    check("R1 virq after reset", virqOut, 0);
    doRead(2'd0, d); check("R1 control after reset", d, 0);
    doRead(2'd1, d); check("R1 mask after reset", d, 0);
    doRead(2'd2, d); check("R4 ack while empty", d, 1023);
  endtask

  task automatic testRegs();
    logic [31:0] d;
    doWrite(2'd1, 32'h3A5);
    doRead(2'd1, d); check("R10 mask keeps five bits", d, 5);
    doWrite(2'd0, 32'hFFFF_FFFF);
    doRead(2'd0, d); check("R10 control readback", d, 1);
    doRead(2'd3, d); check("R10 eoi address reads zero", d, 0);
    doWrite(2'd2, 32'h1234);
    @(negedge clk); check("R10 ack write ignored", emptyStatus, 4'hF);
  endtask

  task automatic testLoadAndOrder();
    logic [31:0] d;
    doLoad(2'd0, 10'd33, 3'd2, 2'b01, 5'd8, 1'b0, 1'b0);
    @(negedge clk);
    check("R2 empty after one load", emptyStatus, 4'b1110);
    check("R9 virq with pending", virqOut, 1);
    doLoad(2'd1, 10'd100, 3'd1, 2'b01, 5'd3, 1'b0, 1'b0);
    doLoad(2'd2, 10'd200, 3'd0, 2'b01, 5'd3, 1'b0, 1'b0);
    doRead(2'd2, d); check("R3 lowest prio tie to lowest index", d, (1 << 10) | 100);
    doRead(2'd2, d); check("R3 next in tie", d, 200);
    doRead(2'd2, d); check("R3 highest prio value last", d, (2 << 10) | 33);
    doRead(2'd2, d); check("R4 ack with all active", d, 1023);
    @(negedge clk);
    check("R9 virq drops with none pending", virqOut, 0);
    check("R2 active entries not empty", emptyStatus, 4'b1000);
  endtask

  task automatic testEoi();
    doWrite(2'd3, (1 << 10) | 100);
    @(negedge clk); check("R6 matching eoi clears entry", emptyStatus, 4'b1010);
    doWrite(2'd3, 33);
    @(negedge clk); check("R7 cpu mismatch ignored", emptyStatus, 4'b1010);
    doWrite(2'd3, (2 << 10) | 999);
    @(negedge clk); check("R7 id mismatch ignored", emptyStatus, 4'b1010);
  endtask

  task automatic testNotify();
    doLoad(2'd3, 10'd5, 3'd0, 2'b10, 5'd0, 1'b1, 1'b0);
    @(negedge clk); check("R8 live entry no notify", eoiStatus, 4'b0000);
    doWrite(2'd3, 5);
    @(negedge clk);
    check("R8 retired entry notifies", eoiStatus, 4'b1000);
    check("R6 retired entry empty", emptyStatus, 4'b1010);
    doLoad(2'd1, 10'd0, 3'd0, 2'b00, 5'd0, 1'b1, 1'b0);
    @(negedge clk); check("R8 loaded invalid with notify", eoiStatus, 4'b1010);
  endtask

  task automatic testDisable();
    logic [31:0] d;
    doLoad(2'd1, 10'd7, 3'd3, 2'b01, 5'd1, 1'b0, 1'b0);
    @(negedge clk); check("R8 notify drops when live", eoiStatus, 4'b1000);
    doWrite(2'd0, 0);
    @(negedge clk); check("R9 virq low when disabled", virqOut, 0);
    doRead(2'd2, d); check("R4 ack while disabled", d, 1023);
    doWrite(2'd0, 1);
    @(negedge clk); check("R9 virq back on enable", virqOut, 1);
    doRead(2'd2, d); check("R4 disabled ack left entry pending", d, (3 << 10) | 7);
  endtask

  task automatic testHw();
    logic [31:0] d;
    doLoad(2'd1, 10'd9, 3'd0, 2'b01, 5'd0, 1'b0, 1'b1);
    doRead(2'd2, d); check("R5 hardware-linked ack refused", d, 1023);
    @(negedge clk); check("R5 entry still pending", virqOut, 1);
    doLoad(2'd1, 10'd9, 3'd0, 2'b01, 5'd0, 1'b0, 1'b0);
    doRead(2'd2, d); check("R5 plain entry acked", d, 9);
  endtask

  task automatic testCollision();
    logic [31:0] d;
    doLoad(2'd1, 10'd12, 3'd0, 2'b01, 5'd0, 1'b0, 1'b0);
    @(negedge clk);
    setLoad(2'd1, 10'd13, 3'd0, 2'b01, 5'd0, 1'b0, 1'b0);
    busValid = 1'b1; busWrite = 1'b0; busAddr = 2'd2;
    #1 d = busRdata;
    @(posedge clk); #1 busValid = 1'b0; ldValid = 1'b0;
    check("R11 read shows old entry", d, 12);
    doRead(2'd2, d); check("R11 load beats ack", d, 13);
    @(negedge clk);
    setLoad(2'd2, 10'd201, 3'd0, 2'b10, 5'd0, 1'b0, 1'b0);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 2'd3; busWdata = 200;
    @(posedge clk); #1 busValid = 1'b0; busWrite = 1'b0; ldValid = 1'b0;
    @(negedge clk); check("R11 load beats eoi", emptyStatus[2], 0);
    doWrite(2'd3, 201);
    @(negedge clk); check("R6 loaded entry retired", emptyStatus[2], 1);
  endtask

  task automatic testPendActive();
    logic [31:0] d;
    doLoad(2'd3, 10'd20, 3'd0, 2'b11, 5'd0, 1'b0, 1'b0);
    @(negedge clk); check("R9 pending-and-active raises virq", virqOut, 1);
    doRead(2'd2, d); check("R3 pending-and-active acked", d, 20);
    @(negedge clk); check("R3 acked entry now active only", virqOut, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testRegs();
    testLoadAndOrder();
    testEoi();
    testNotify();
    testDisable();
    testHw();
    testCollision();
    testPendActive();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule